// File: doc/BRIEF.md
# Multithreaded Register Renaming Unit

This block translates the architectural register names of up to four hardware threads into tags of a single shared pool of physical registers. Every thread owns a private map table, so two threads that name the same architectural register never collide, while all threads draw new destination registers from one common free pool. Once renamed, an operand is known only by its physical tag, which removes false write-after-write and write-after-read dependences inside a thread and between threads alike.

Each cycle the front end may present up to two rename lanes, each with a thread ID, two source registers and an optional destination. The group is accepted as a whole on a valid/ready handshake, and the unit returns, combinationally in the same cycle, the physical tags of the sources, the newly allocated destination tag and the tag the destination was mapped to before. A later lane of the same thread in the same group sees the earlier lane's new mapping. Retirement reports one committed instruction per cycle so its old tag can be recycled; a per-thread flush rolls that thread's map back to its committed state and reclaims every register the thread allocated but never committed.

Top module: `mt_rename`

## Requirements
- R1: After reset, thread t maps architectural register r to physical tag 32*t+r (4 threads, 32 registers each, 160 tags), and tags 128..159 are free.
- R2: A lane with a destination receives the lowest-numbered free tag; when both lanes need one, lane 0 gets the lowest and lane 1 the next lowest. `ren_pold` returns the destination's mapping in force before the group.
- R3: After a rename is accepted, later lookups of the same thread and register return the new tag; the maps of other threads are unchanged.
- R4: When lane 1 has the same thread ID as lane 0 and lane 0 writes a destination, lane 1's sources and old tag equal to lane 0's destination see lane 0's new tag; lanes of different threads never bypass.
- R5: `ren_ready` is low when the free pool holds fewer tags than the number of valid lanes with a destination; groups without destinations are accepted with an empty pool.
- R6: A commit (thread, architectural register, new tag, old tag) returns the old tag to the free pool, usable for allocation from the next cycle.
- R7: A flush of thread t copies t's committed map into its working map and returns every tag t allocated and did not commit to the pool; other threads' maps and allocations are untouched.
- R8: In a flush cycle `ren_ready` is low; a commit in the same cycle for the flushed thread is applied to the committed map before the restore.
- R9: No tag is ever handed out while in use: the two lanes receive distinct tags and the free count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 2 | Per-lane rename request valid |
| ren_ready | output | 1 | Whole group accepted this cycle |
| ren_tid | input | 2x2 | Per-lane thread ID |
| ren_srca | input | 2x5 | Per-lane first source register |
| ren_srcb | input | 2x5 | Per-lane second source register |
| ren_dst | input | 2x5 | Per-lane destination register |
| ren_has_dst | input | 2 | Per-lane destination present |
| ren_psrca | output | 2x8 | Physical tag of first source |
| ren_psrcb | output | 2x8 | Physical tag of second source |
| ren_pdst | output | 2x8 | Newly allocated destination tag |
| ren_pold | output | 2x8 | Previous tag of the destination |
| cmt_valid | input | 1 | Commit valid |
| cmt_tid | input | 2 | Committing thread |
| cmt_arch | input | 5 | Committed architectural register |
| cmt_pnew | input | 8 | Tag becoming architectural |
| cmt_pold | input | 8 | Tag released to the pool |
| fl_valid | input | 1 | Flush valid |
| fl_tid | input | 2 | Thread to flush |

## Verification
A sweep of source-only lookups over every thread and register confirms the reset mapping and separates per-thread indexing from a shared table. Paired lanes of the same thread and of different threads tell the bypass apart from a plain table read, and draining the pool to zero distinguishes the stall threshold from an off-by-one count. A long mixed run of renames, in-order commits and flushes against an arithmetic model shows whether reclaimed tags and restored maps stay consistent across threads.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_THREADS = 4;
  localparam int DEF_ARCH    = 32;
  localparam int DEF_PHYS    = 160;
  localparam int DEF_LANES   = 2;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int NT = 4,
  parameter int NP = 160,
  parameter int NL = 2,
  parameter int RESV = 128,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int PW = $clog2(NP),
  localparam int CW = $clog2(NP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NL-1:0]          want,
  input  logic                   alloc_go,
  input  logic [NL-1:0][TW-1:0]  alloc_tid,
  output logic [NL-1:0][PW-1:0]  alloc_tag,
  input  logic                   cmt_valid,
  input  logic [TW-1:0]          cmt_tid,
  input  logic [PW-1:0]          cmt_pnew,
  input  logic [PW-1:0]          cmt_pold,
  input  logic                   fl_valid,
  input  logic [TW-1:0]          fl_tid,
  output logic [CW-1:0]          free_cnt
);
  logic [NP-1:0]         free_q, free_d, avail;
  logic [NT-1:0][NP-1:0] own_q, own_d;
  logic [CW-1:0]         cnt_d;
  logic                  upd;

  // priority pick: each requesting lane takes the lowest tag left
  always_comb begin
    logic hit;
    avail = free_q;
    for (int l = 0; l < NL; l++) begin
      alloc_tag[l] = '0;
      hit = 1'b0;
      for (int p = 0; p < NP; p++) begin
        if (want[l] && !hit && avail[p]) begin
          alloc_tag[l] = PW'(p);
          hit = 1'b1;
        end
      end
      if (want[l] && hit) avail[alloc_tag[l]] = 1'b0;
    end
  end

  // order inside a cycle: allocate, then commit, then flush
  always_comb begin
    free_d = free_q;
    own_d  = own_q;
    if (alloc_go) begin
      for (int l = 0; l < NL; l++) begin
        if (want[l]) begin
          free_d[alloc_tag[l]] = 1'b0;
          own_d[alloc_tid[l]][alloc_tag[l]] = 1'b1;
        end
      end
    end
    if (cmt_valid) begin
      free_d[cmt_pold] = 1'b1;
      own_d[cmt_tid][cmt_pnew] = 1'b0;
    end
    if (fl_valid) begin
      free_d = free_d | own_d[fl_tid];
      own_d[fl_tid] = '0;
    end
    cnt_d = CW'($countones(free_d));
  end

  assign upd = alloc_go | cmt_valid | fl_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) free_q[p] <= (p >= RESV);
      own_q    <= '0;
      free_cnt <= CW'(NP - RESV);
    end else if (upd) begin
      free_q   <= free_d;
      own_q    <= own_d;
      free_cnt <= cnt_d;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_chk
    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_go && want[l]) |-> free_q[alloc_tag[l]]); // R9
  end
  if (NL > 1) begin : g_dist
    AST_ALLOC_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_go && want[0] && want[1]) |-> (alloc_tag[0] != alloc_tag[1])); // R9
  end
  AST_CMT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> free_q[$past(cmt_pold)]); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) <= NP - RESV); // R9
endmodule

// File: rtl/rn_map_bank.sv
module rn_map_bank #(
  parameter int NT = 4,
  parameter int NA = 32,
  parameter int NP = 160,
  parameter int NL = 2,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int AW = $clog2(NA),
  localparam int PW = $clog2(NP)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NL-1:0][TW-1:0]  rd_tid,
  input  logic [NL-1:0][AW-1:0]  rd_a,
  input  logic [NL-1:0][AW-1:0]  rd_b,
  input  logic [NL-1:0][AW-1:0]  rd_d,
  output logic [NL-1:0][PW-1:0]  rd_pa,
  output logic [NL-1:0][PW-1:0]  rd_pb,
  output logic [NL-1:0][PW-1:0]  rd_pd,
  input  logic [NL-1:0]          wr_en,
  input  logic [NL-1:0][PW-1:0]  wr_tag,
  input  logic                   cmt_valid,
  input  logic [TW-1:0]          cmt_tid,
  input  logic [AW-1:0]          cmt_arch,
  input  logic [PW-1:0]          cmt_pnew,
  input  logic                   fl_valid,
  input  logic [TW-1:0]          fl_tid
);
  logic [NT-1:0][NA-1:0][PW-1:0] spec_q, spec_d, arch_q, arch_d;
  logic spec_en, arch_en;

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      rd_pa[l] = spec_q[rd_tid[l]][rd_a[l]];
      rd_pb[l] = spec_q[rd_tid[l]][rd_b[l]];
      rd_pd[l] = spec_q[rd_tid[l]][rd_d[l]];
    end
  end

  always_comb begin
    spec_d = spec_q;
    arch_d = arch_q;
    for (int l = 0; l < NL; l++)
      if (wr_en[l]) spec_d[rd_tid[l]][rd_d[l]] = wr_tag[l];
    if (cmt_valid) arch_d[cmt_tid][cmt_arch] = cmt_pnew;
    if (fl_valid) spec_d[fl_tid] = arch_d[fl_tid];
  end

  assign spec_en = (|wr_en) | fl_valid;
  assign arch_en = cmt_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++)
        for (int r = 0; r < NA; r++) begin
          spec_q[t][r] <= PW'(t * NA + r);
          arch_q[t][r] <= PW'(t * NA + r);
        end
    end else begin
      if (spec_en) spec_q <= spec_d;
      if (arch_en) arch_q <= arch_d;
    end
  end

  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> (spec_q[$past(fl_tid)] == arch_q[$past(fl_tid)])); // R7
endmodule

// File: rtl/mt_rename.sv
module mt_rename
  import rn_pkg::*;
#(
  parameter int NUM_THR   = DEF_THREADS,
  parameter int ARCH_REGS = DEF_ARCH,
  parameter int PHYS_REGS = DEF_PHYS,
  parameter int LANES     = DEF_LANES,
  localparam int TW = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS),
  localparam int CW = $clog2(PHYS_REGS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          ren_valid,
  output logic                      ren_ready,
  input  logic [LANES-1:0][TW-1:0]  ren_tid,
  input  logic [LANES-1:0][AW-1:0]  ren_srca,
  input  logic [LANES-1:0][AW-1:0]  ren_srcb,
  input  logic [LANES-1:0][AW-1:0]  ren_dst,
  input  logic [LANES-1:0]          ren_has_dst,
  output logic [LANES-1:0][PW-1:0]  ren_psrca,
  output logic [LANES-1:0][PW-1:0]  ren_psrcb,
  output logic [LANES-1:0][PW-1:0]  ren_pdst,
  output logic [LANES-1:0][PW-1:0]  ren_pold,
  input  logic                      cmt_valid,
  input  logic [TW-1:0]             cmt_tid,
  input  logic [AW-1:0]             cmt_arch,
  input  logic [PW-1:0]             cmt_pnew,
  input  logic [PW-1:0]             cmt_pold,
  input  logic                      fl_valid,
  input  logic [TW-1:0]             fl_tid
);
  localparam int RESV = NUM_THR * ARCH_REGS;

  logic [LANES-1:0]         want, wr_en;
  logic [LANES-1:0][PW-1:0] tag, rd_pa, rd_pb, rd_pd;
  logic [CW-1:0]            free_cnt;
  logic                     fire;
  int                       need;

  assign want = ren_valid & ren_has_dst;

  always_comb begin
    need = 0;
    for (int l = 0; l < LANES; l++) need = need + int'(want[l]);
  end

  assign ren_ready = !fl_valid && (int'(free_cnt) >= need);
  assign fire      = ren_ready && (|ren_valid);
  assign wr_en     = want & {LANES{fire}};

  rn_free_pool #(.NT(NUM_THR), .NP(PHYS_REGS), .NL(LANES), .RESV(RESV)) u_pool (
    .clk(clk), .rst_n(rst_n), .want(want), .alloc_go(fire), .alloc_tid(ren_tid),
    .alloc_tag(tag), .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_pnew(cmt_pnew),
    .cmt_pold(cmt_pold), .fl_valid(fl_valid), .fl_tid(fl_tid), .free_cnt(free_cnt)
  );

  rn_map_bank #(.NT(NUM_THR), .NA(ARCH_REGS), .NP(PHYS_REGS), .NL(LANES)) u_maps (
    .clk(clk), .rst_n(rst_n), .rd_tid(ren_tid), .rd_a(ren_srca), .rd_b(ren_srcb),
    .rd_d(ren_dst), .rd_pa(rd_pa), .rd_pb(rd_pb), .rd_pd(rd_pd), .wr_en(wr_en),
    .wr_tag(tag), .cmt_valid(cmt_valid), .cmt_tid(cmt_tid), .cmt_arch(cmt_arch),
    .cmt_pnew(cmt_pnew), .fl_valid(fl_valid), .fl_tid(fl_tid)
  );

  // intra-group bypass: the youngest earlier lane of the same thread wins
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      ren_psrca[l] = rd_pa[l];
      ren_psrcb[l] = rd_pb[l];
      ren_pold[l]  = rd_pd[l];
      ren_pdst[l]  = tag[l];
      for (int j = 0; j < l; j++) begin
        if (want[j] && (ren_tid[j] == ren_tid[l])) begin
          if (ren_srca[l] == ren_dst[j]) ren_psrca[l] = tag[j];
          if (ren_srcb[l] == ren_dst[j]) ren_psrcb[l] = tag[j];
          if (ren_dst[l]  == ren_dst[j]) ren_pold[l]  = tag[j];
        end
      end
    end
  end

  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |-> !ren_ready); // R8
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0 && (|want)) |-> !ren_ready); // R5
endmodule

// File: tb/mt_rename_tb.sv
module mt_rename_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2ns clk = ~clk;

  logic [1:0]      rv, rh, rdy;
  logic [1:0][1:0] rt;
  logic [1:0][4:0] rsa, rsb, rd;
  logic [1:0][7:0] psa, psb, pdst, pold;
  logic       cv, fv;
  logic [1:0] ct, ft;
  logic [4:0] ca;
  logic [7:0] cpn, cpo;

  mt_rename dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(rv), .ren_ready(rdy[0]), .ren_tid(rt),
    .ren_srca(rsa), .ren_srcb(rsb), .ren_dst(rd), .ren_has_dst(rh),
    .ren_psrca(psa), .ren_psrcb(psb), .ren_pdst(pdst), .ren_pold(pold),
    .cmt_valid(cv), .cmt_tid(ct), .cmt_arch(ca), .cmt_pnew(cpn), .cmt_pold(cpo),
    .fl_valid(fv), .fl_tid(ft)
  );
  assign rdy[1] = 1'b0;

  int checks = 0, fails = 0;
  int m[4][32], cm[4][32];
  bit fr[160];
  bit ow[4][160];
  int pa[4][64], pn[4][64], po[4][64], ph[4], pt[4];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rv = '0; rh = '0; rt = '0; rsa = '0; rsb = '0; rd = '0;
    cv = 1'b0; ct = '0; ca = '0; cpn = '0; cpo = '0; fv = 1'b0; ft = '0;
  endtask

  task automatic set_cmt(int t);
    if (ph[t] < pt[t]) begin
      cv = 1'b1; ct = 2'(t); ca = 5'(pa[t][ph[t]]);
      cpn = 8'(pn[t][ph[t]]); cpo = 8'(po[t][ph[t]]);
    end else cv = 1'b0;
  endtask

  task automatic cyc(string req);
    int a0, a1, need, fc, tg[2];
    bit er, go;
    #1ns;
    a0 = -1; a1 = -1; fc = 0;
    for (int p = 0; p < 160; p++) if (fr[p]) begin
      fc++;
      if (a0 < 0) a0 = p; else if (a1 < 0) a1 = p;
    end
    need = int'(rv[0] & rh[0]) + int'(rv[1] & rh[1]);
    er = !fv && (fc >= need);
    tg[0] = a0;
    tg[1] = (rv[0] & rh[0]) ? a1 : a0;
    chk(req, "ready", int'(rdy[0]), int'(er));
    go = er && (rv != 0);
    if (go) begin
      for (int l = 0; l < 2; l++) if (rv[l]) begin
        int t, ea, eb, eo;
        t = int'(rt[l]);
        ea = m[t][rsa[l]]; eb = m[t][rsb[l]]; eo = m[t][rd[l]];
        if (l == 1 && rv[0] && rh[0] && rt[0] == rt[1]) begin
          if (rsa[1] == rd[0]) ea = tg[0];
          if (rsb[1] == rd[0]) eb = tg[0];
          if (rd[1] == rd[0]) eo = tg[0];
        end
        chk(req, $sformatf("lane%0d srca", l), int'(psa[l]), ea);
        chk(req, $sformatf("lane%0d srcb", l), int'(psb[l]), eb);
        if (rh[l]) begin
          chk(req, $sformatf("lane%0d pdst", l), int'(pdst[l]), tg[l]);
          chk(req, $sformatf("lane%0d pold", l), int'(pold[l]), eo);
        end
      end
    end
    @(posedge clk);
    if (go) for (int l = 0; l < 2; l++) if (rv[l] && rh[l]) begin
      int t;
      t = int'(rt[l]);
      pa[t][pt[t]] = int'(rd[l]); pn[t][pt[t]] = tg[l]; po[t][pt[t]] = m[t][rd[l]];
      pt[t]++;
      m[t][rd[l]] = tg[l]; fr[tg[l]] = 0; ow[t][tg[l]] = 1;
    end
    if (cv) begin
      cm[ct][ca] = int'(cpn); fr[cpo] = 1; ow[ct][cpn] = 0; ph[ct]++;
    end
    if (fv) begin
      for (int p = 0; p < 160; p++) if (ow[ft][p]) begin fr[p] = 1; ow[ft][p] = 0; end
      for (int r = 0; r < 32; r++) m[ft][r] = cm[ft][r];
      ph[ft] = 0; pt[ft] = 0;
    end
    @(negedge clk);
  endtask

  task automatic lane(int l, int t, int a, int b, int d, bit h);
    rv[l] = 1'b1; rt[l] = 2'(t); rsa[l] = 5'(a); rsb[l] = 5'(b); rd[l] = 5'(d); rh[l] = h;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) begin
      ph[t] = 0; pt[t] = 0;
      for (int r = 0; r < 32; r++) begin m[t][r] = 32*t + r; cm[t][r] = 32*t + r; end
    end
    for (int p = 0; p < 160; p++) begin
      fr[p] = (p >= 128);
      for (int t = 0; t < 4; t++) ow[t][p] = 0;
    end
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1");
    // R1: sweep every thread and register with source-only lookups
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 32; r += 2) begin
        idle();
        lane(0, t, r, r + 1, 0, 0);
        lane(1, (t + 1) % 4, 31 - r, r, 0, 0);
        cyc("R1");
      end
    // R2: two allocations from different threads
    idle(); lane(0, 0, 1, 2, 5, 1); lane(1, 1, 3, 4, 7, 1); cyc("R2");
    // R4: same-thread bypass, then different threads
    idle(); lane(0, 3, 1, 2, 4, 1); lane(1, 3, 4, 4, 4, 1); cyc("R4");
    idle(); lane(0, 2, 1, 2, 4, 1); lane(1, 1, 4, 4, 4, 1); cyc("R4");
    // R3: read back new mappings and neighbours
    idle(); lane(0, 0, 5, 4, 0, 0); lane(1, 1, 7, 4, 0, 0); cyc("R3");
    idle(); lane(0, 3, 4, 5, 0, 0); lane(1, 2, 4, 7, 0, 0); cyc("R3");
    // R5: drain the pool (26 left) with thread 2
    for (int i = 0; i < 13; i++) begin
      idle(); lane(0, 2, i, i + 1, i, 1); lane(1, 2, i + 2, i, i + 16, 1); cyc("R5");
    end
    idle(); lane(0, 1, 3, 3, 9, 1); cyc("R5");
    idle(); lane(0, 1, 3, 3, 9, 0); lane(1, 0, 5, 6, 0, 0); cyc("R5");
    // R6: commit returns a tag which is then allocated
    idle(); set_cmt(2); cyc("R6");
    idle(); lane(0, 1, 3, 3, 9, 1); lane(1, 0, 9, 9, 8, 1); cyc("R6");
    idle(); lane(0, 1, 9, 7, 10, 1); cyc("R6");
    // R8: flush with rename pending and same-thread commit
    idle(); lane(0, 2, 1, 2, 3, 1); set_cmt(2); fv = 1'b1; ft = 2'd2; cyc("R8");
    // R7: thread 2 restored, others kept, pool refilled
    idle(); lane(0, 2, 0, 1, 0, 0); lane(1, 2, 16, 2, 0, 0); cyc("R7");
    idle(); lane(0, 3, 4, 4, 0, 0); lane(1, 1, 7, 9, 0, 0); cyc("R7");
    idle(); lane(0, 2, 0, 1, 2, 1); lane(1, 2, 2, 16, 2, 1); cyc("R7");
    // R9: mixed traffic with commits and flushes
    for (int i = 0; i < 4000; i++) begin
      int t0, t1;
      idle();
      t0 = $urandom_range(0, 3);
      t1 = ($urandom_range(0, 1) == 0) ? t0 : $urandom_range(0, 3);
      if ($urandom_range(0, 3) != 0)
        lane(0, t0, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
             $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 3) != 0)
        lane(1, t1, $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
             $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 2) != 0) set_cmt($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) begin fv = 1'b1; ft = 2'($urandom_range(0, 3)); end
      cyc("R9");
    end
    idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule